// File: doc/BRIEF.md
# Flash Program/Erase Busy-Status Responder

This block models the device side of one byte lane of a parallel NOR flash, for use as a synthesizable partner when testing a host-side flash controller. It holds a small byte array, which is grouped into equal sectors. It watches ordinary bus writes for the unlock-and-command sequences that start a byte program or an erase. Once it sees one, it latches the target address and data and enters a busy window whose length, counted in clock cycles, is set by a parameter.

While the window is open, the ready output is low and reads return status instead of stored data. Bit 7 gives completion information and bit 6 flips on each read, so a host can poll the block either by comparing data or by watching the toggle. An erase can be paused to reach the sectors it is not erasing, then continued. The active-low reset aborts any operation and leaves the block in array-read mode.

Command data codes are the 8-bit values AA, 55, A0, 80, 30, 10 and B0 (hex). The address is not decoded on unlock or setup cycles. It is used only on the cycle that names a program target or an erase sector. The sector number is the top `SB` bits of the address.

Top module: `flash_op_status`

## Requirements
- R1: The write sequence AA, 55, A0, followed by a write of D to address A, starts a program of byte A. Any other data value breaks the sequence, and the block then waits for AA again.
- R2: A program keeps ready low for exactly PROG_CYC cycles after the target write. At the end it stores the old byte ANDed with D, so programming can only clear bits.
- R3: During a program, a read at any address returns the complement of D bit 7 in bit 7 and zeros in bits 5:0.
- R4: Each read taken while an operation is running inverts bit 6 of the next busy read.
- R5: Ready is low for the whole of a program or a running erase, and high otherwise.
- R6: The sequence AA, 55, 80, AA, 55 followed by 30 written to an address in sector S erases sector S. The same sequence ending in 10 erases every sector. After ERASE_CYC running cycles, every byte of the target sector(s) reads FF. Other sectors are left unchanged.
- R7: While a program is running, every write is ignored. While an erase is running and not suspended, every write except B0 is ignored.
- R8: Writing B0 during a running erase suspends it, and ready goes high. Reads of sectors outside the erase return array data. Reads of the sector being erased return 80.
- R9: While an erase is suspended, a program to a sector outside the erase runs normally. A program aimed at the sector being erased is dropped and never raises busy.
- R10: Writing 30 while suspended and idle resumes the erase. Ready goes low again, and the erase finishes with the cycles it had left.
- R11: Asserting rst_n low ends any program or erase without changing the array. The block then reads array data with ready high.
- R12: During a running erase, a read returns 0 in bit 7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| wr_en | input | 1 | Bus write strobe, one cycle per write |
| rd_en | input | 1 | Bus read strobe, one cycle per read |
| addr | input | AW | Byte address |
| wdata | input | 8 | Write data or command code |
| rdata | output | 8 | Array data or status, valid in the read cycle |
| ready | output | 1 | High when no program or running erase is in progress |

## Verification
The assertions assume that a read and a write never fall in the same cycle, and that each strobe lasts exactly one cycle with the address and data held for that cycle. The toggle check also assumes that no write comes between two back-to-back busy reads. This rules out the case where an erase is resumed between those two reads. The stimulus keeps within these limits: each bus operation is driven on a falling edge, held for one cycle and then released, and reads and writes are always issued one after another, never together.

// File: rtl/flash_op_status.sv
module flash_op_status #(
  parameter int AW        = 6,
  parameter int SB        = 2,
  parameter int PROG_CYC  = 20,
  parameter int ERASE_CYC = 60
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [7:0]    wdata,
  output logic [7:0]    rdata,
  output logic          ready
);
  localparam int DEPTH = 1 << AW;
  localparam int NSECT = 1 << SB;
  localparam int PCW   = $clog2(PROG_CYC + 1);
  localparam int ECW   = $clog2(ERASE_CYC + 1);

  localparam logic [7:0] K_UNL1  = 8'hAA;
  localparam logic [7:0] K_UNL2  = 8'h55;
  localparam logic [7:0] K_PROG  = 8'hA0;
  localparam logic [7:0] K_ERASE = 8'h80;
  localparam logic [7:0] K_SECT  = 8'h30;
  localparam logic [7:0] K_CHIP  = 8'h10;
  localparam logic [7:0] K_SUSP  = 8'hB0;

  typedef enum logic [2:0] {C_IDLE, C_U1, C_U2, C_PSET, C_E1, C_E2, C_E3} cst_t;

  cst_t            cst;
  logic            pbusy, ebusy, esusp, tog;
  logic [PCW-1:0]  pcnt;
  logic [ECW-1:0]  ecnt;
  logic [AW-1:0]   paddr;
  logic [7:0]      pdata;
  logic [NSECT-1:0] emask;
  logic [7:0]      mem [DEPTH];

  wire [SB-1:0] sec     = addr[AW-1 -: SB];
  wire          running = pbusy | (ebusy & ~esusp);
  wire          prog_done  = pbusy & (pcnt == '0);
  wire          erase_done = ebusy & ~esusp & (ecnt == '0);

  assign ready = ~running;

  always_comb begin
    if (pbusy)
      rdata = {~pdata[7], tog, 6'b0};
    else if (ebusy && !esusp)
      rdata = {1'b0, tog, 6'b0};
    else if (ebusy && emask[sec])
      rdata = 8'h80;
    else
      rdata = mem[addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cst   <= C_IDLE;
      pbusy <= 1'b0;
      ebusy <= 1'b0;
      esusp <= 1'b0;
      tog   <= 1'b0;
      pcnt  <= '0;
      ecnt  <= '0;
      paddr <= '0;
      pdata <= '0;
      emask <= '0;
    end else begin
      if (rd_en && running) tog <= ~tog;

      if (wr_en && !pbusy) begin
        if (ebusy && !esusp) begin
          if (wdata == K_SUSP) esusp <= 1'b1;
        end else begin
          case (cst)
            C_IDLE: begin
              if (wdata == K_UNL1) cst <= C_U1;
              else if (esusp && wdata == K_SECT) esusp <= 1'b0;
            end
            C_U1: cst <= (wdata == K_UNL2) ? C_U2 : C_IDLE;
            C_U2: begin
              if (wdata == K_PROG) cst <= C_PSET;
              else if (wdata == K_ERASE && !ebusy) cst <= C_E1;
              else cst <= C_IDLE;
            end
            C_PSET: begin
              cst <= C_IDLE;
              if (!(ebusy && emask[sec])) begin
                pbusy <= 1'b1;
                pcnt  <= PCW'(PROG_CYC - 1);
                paddr <= addr;
                pdata <= wdata;
              end
            end
            C_E1: cst <= (wdata == K_UNL1) ? C_E2 : C_IDLE;
            C_E2: cst <= (wdata == K_UNL2) ? C_E3 : C_IDLE;
            C_E3: begin
              cst <= C_IDLE;
              if (wdata == K_SECT || wdata == K_CHIP) begin
                ebusy <= 1'b1;
                ecnt  <= ECW'(ERASE_CYC - 1);
                emask <= (wdata == K_CHIP) ? {NSECT{1'b1}} : (NSECT'(1) << sec);
              end
            end
            default: cst <= C_IDLE;
          endcase
        end
      end

      if (pbusy) begin
        if (pcnt == '0) pbusy <= 1'b0;
        else pcnt <= pcnt - 1'b1;
      end

      if (ebusy && !esusp) begin
        if (ecnt == '0) begin
          ebusy <= 1'b0;
          esusp <= 1'b0;
          emask <= '0;
        end else begin
          ecnt <= ecnt - 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && prog_done)
      mem[paddr] <= mem[paddr] & pdata;
    if (rst_n && erase_done)
      for (int i = 0; i < DEPTH; i++)
        if (emask[i >> (AW - SB)]) mem[i] <= 8'hFF;
  end

  AST_PROG_LATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pbusy && wr_en) |=> ($stable(paddr) && $stable(pdata))); // R7
  AST_PROG_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> ((mem[$past(paddr)] & ~$past(mem[paddr])) == 8'h00)); // R2
  AST_TOGGLE_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !ready && $past(rd_en && !ready)) |-> (rdata[6] != $past(rdata[6]))); // R4
  AST_SUSPEND_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(esusp) |-> ready); // R8
  AST_PROG_IN_SUSPEND: assert property (@(posedge clk) disable iff (!rst_n)
    pbusy |-> (!ebusy || esusp)); // R9
  AST_RESET_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && !$past(rst_n)) |-> (ready && cst == C_IDLE)); // R11
endmodule

// File: tb/sim_flash_op_status.sv
module sim_flash_op_status;
  localparam int AW = 6, SB = 2, PROG_CYC = 20, ERASE_CYC = 60;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0, rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic          ready;
  int checks = 0, errors = 0;

  flash_op_status #(.AW(AW), .SB(SB), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .ready(ready));

  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = AW'(a); wdata = 8'(d);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [7:0] d);
    @(negedge clk); rd_en = 1'b1; addr = AW'(a);
    #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wait_ready(output int n);
    n = 0;
    while (!ready && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic prog_start(input int a, input int d);
    wr(0, 'hAA); wr(0, 'h55); wr(0, 'hA0); wr(a, d);
  endtask

  task automatic erase_start(input int a, input int code);
    wr(0, 'hAA); wr(0, 'h55); wr(0, 'h80); wr(0, 'hAA); wr(0, 'h55); wr(a, code);
  endtask

  task automatic t_reset_state;
    chk(ready === 1'b1, "R11 ready after reset", ready, 1);
  endtask

  task automatic t_chip_erase;
    int n; logic [7:0] d;
    erase_start(0, 'h10);
    wait_ready(n);
    chk(n == ERASE_CYC, "R5 chip erase busy length", n, ERASE_CYC);
    rd(0, d);  chk(d == 8'hFF, "R6 chip erase addr 0", d, 'hFF);
    rd(33, d); chk(d == 8'hFF, "R6 chip erase addr 33", d, 'hFF);
    rd(63, d); chk(d == 8'hFF, "R6 chip erase addr 63", d, 'hFF);
  endtask

  task automatic t_program;
    int n; logic [7:0] d;
    prog_start(5, 'h3C);
    wait_ready(n);
    chk(n == PROG_CYC, "R2 program busy length", n, PROG_CYC);
    rd(5, d); chk(d == 8'h3C, "R1 programmed byte", d, 'h3C);
    prog_start(5, 'hF0);
    wait_ready(n);
    rd(5, d); chk(d == 8'h30, "R2 program ANDs with old data", d, 'h30);
    wr(0, 'hAA); wr(0, 'h12); wr(0, 'hA0); wr(11, 'h00);
    chk(ready === 1'b1, "R1 broken sequence no busy", ready, 1);
    rd(11, d); chk(d == 8'hFF, "R1 broken sequence no program", d, 'hFF);
  endtask

  task automatic t_status;
    int n; logic [7:0] d1, d2;
    prog_start(10, 'h5A);
    rd(40, d1);
    chk(d1[7] == 1'b1 && d1[5:0] == 6'd0, "R3 status complement bit7", d1, 'h80);
    rd(40, d2);
    chk(d2[6] != d1[6], "R4 toggle during program", d2, d1 ^ 8'h40);
    chk(ready === 1'b0, "R5 busy during program", ready, 0);
    wait_ready(n);
    rd(10, d1); chk(d1 == 8'h5A, "R2 data after status", d1, 'h5A);
  endtask

  task automatic t_ignore;
    int n; logic [7:0] d;
    prog_start(8, 'h00);
    wr(0, 'hAA); wr(0, 'h55); wr(0, 'hA0); wr(9, 'h00); wr(0, 'hB0);
    wait_ready(n);
    rd(9, d); chk(d == 8'hFF, "R7 writes during program ignored", d, 'hFF);
    rd(8, d); chk(d == 8'h00, "R7 first program kept", d, 'h00);
  endtask

  task automatic t_sector_erase;
    int n; logic [7:0] d1, d2;
    prog_start(20, 'h00); wait_ready(n);
    erase_start(16, 'h30);
    rd(2, d1); chk(d1[7] == 1'b0, "R12 erase status bit7", d1, 0);
    rd(2, d2); chk(d2[6] != d1[6], "R4 toggle during erase", d2, d1 ^ 8'h40);
    wr(0, 'h44);
    wait_ready(n);
    rd(20, d1); chk(d1 == 8'hFF, "R6 sector erased", d1, 'hFF);
    rd(5, d1);  chk(d1 == 8'h30, "R6 other sector kept", d1, 'h30);
  endtask

  task automatic t_suspend;
    int n; logic [7:0] d;
    prog_start(20, 'h00); wait_ready(n);
    erase_start(16, 'h30);
    repeat (10) @(negedge clk);
    wr(0, 'hB0);
    chk(ready === 1'b1, "R8 ready after suspend", ready, 1);
    rd(5, d);  chk(d == 8'h30, "R8 read outside erase", d, 'h30);
    rd(20, d); chk(d == 8'h80, "R8 read of erasing sector", d, 'h80);
    prog_start(21, 'h00);
    chk(ready === 1'b1, "R9 program to erasing sector dropped", ready, 1);
    prog_start(6, 'h5A);
    wait_ready(n);
    chk(n == PROG_CYC, "R9 program in suspend length", n, PROG_CYC);
    rd(6, d); chk(d == 8'h5A, "R9 program in suspend data", d, 'h5A);
    wr(0, 'h30);
    chk(ready === 1'b0, "R10 busy after resume", ready, 0);
    wait_ready(n);
    chk(n > 0 && n < ERASE_CYC, "R10 remaining erase cycles", n, ERASE_CYC - 12);
    rd(20, d); chk(d == 8'hFF, "R10 erase completed", d, 'hFF);
    rd(6, d);  chk(d == 8'h5A, "R10 other sector intact", d, 'h5A);
  endtask

  task automatic t_hw_reset;
    logic [7:0] d;
    prog_start(7, 'h00);
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    chk(ready === 1'b1, "R11 ready after abort", ready, 1);
    rd(7, d); chk(d == 8'hFF, "R11 aborted program leaves array", d, 'hFF);
    wr(9, 'h00);
    rd(9, d); chk(d == 8'hFF, "R11 read mode after reset", d, 'hFF);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_chip_erase();
    t_program();
    t_status();
    t_ignore();
    t_sector_erase();
    t_suspend();
    t_hw_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule